// File: doc/BRIEF.md
# Double-Buffered 16-bit Compare Timer

This block is a 16-bit up-counting timer meant to sit inside a microcontroller. The counter advances on a count tick. The tick comes either from rising edges of an external count pin or from one of three prescaler taps that divide the system clock by 8, 32 or 128. A run bit gates counting. When the run bit is cleared, the counter is held at zero. Two compare registers, A and B, are checked against the counter on every tick. Each produces a one-cycle match pulse. Compare B can also serve as the period: the counter returns to zero on reaching it.

Compare A can be given a shadow buffer. With double buffering on, software writes land in the buffer only, and the buffer is copied into compare A on the tick where the counter meets compare B. Compare A therefore only ever changes at a period boundary. Two capture registers latch the counter on edges of an external capture pin. Software sees all of this through a byte-wide register bus. Sixteen-bit values are written as a low byte followed by a high byte and read back the same way. Holding registers keep those byte transfers from tearing.

Top module: `cmp_timer16`

## Requirements
- R1: The count source field, control bits [3:2], selects 00 = rising edges of `ext_cnt_in` after a two-flop synchroniser, 01 = system clock divided by 8, 10 = divided by 32, 11 = divided by 128. The counter changes only on a count tick, and the field resets to 00.
- R2: Control bit 0 is the run bit. While it reads 0, no tick occurs and the counter is held at zero. It resets to 0.
- R3: With the clear-enable control bit 1 set, a tick taken while the counter equals compare B returns the counter to zero. With the bit clear, each tick adds one and the counter wraps from 0xFFFF to 0.
- R4: `match_a` / `match_b` pulse high for exactly one clock, in the cycle after a tick taken while the counter equals compare A / compare B.
- R5: Compare A is written with its low byte at address 2 and its high byte at address 3; compare B uses addresses 4 and 5. A low byte is held aside and takes effect only together with the following high-byte write. A low-byte write on its own changes no compare value.
- R6: Control bit 4 enables double buffering and resets to 0. When it is 0, a compare A high-byte write updates both the buffer and compare A. When it is 1, the write updates the buffer only.
- R7: With control bit 4 set, a tick taken while the counter equals compare B copies the buffer into compare A. A buffer write in that same cycle is kept for the next period.
- R8: Control bits [6:5] select capture, with reset value 00 (capture off). Bit 5 makes a rising edge of the synchronised `cap_in` latch the counter into capture 0. Bit 6 makes a falling edge latch it into capture 1.
- R9: Capture 0 is read at addresses 8 (low) and 9 (high), and capture 1 at 10 and 11. `rdata` is valid in the cycle after `rd_en`. A low-byte read freezes that capture's high byte, and the high-byte read returns the frozen byte.
- R10: Reading address 0 returns the 7-bit control register, zero-extended. Its reset value is 0, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_cnt_in | input | 1 | External count pin, asynchronous |
| cap_in | input | 1 | External capture pin, asynchronous |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 4 | Register byte address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, registered |
| match_a | output | 1 | Compare A match pulse |
| match_b | output | 1 | Compare B (period) match pulse |

## Verification
Two functions can fall in the same clock. The period match may coincide with a bus write of compare A's buffer, so the transfer and the write collide. A capture edge may also arrive between the low and high byte reads of that same capture register. Both cases come from random bus traffic mixed with random pin activity, with small compare values so that period matches are frequent. A directed sequence also fires a capture pulse between two byte reads. A cycle-level reference model in the bench computes the expected match pulses and read data from the requirements, and these are compared every cycle and after every read.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int ADDR_W = 4;
  localparam int N_TAP  = 3;
  localparam int N_CMP  = 2;
  localparam int N_CAP  = 2;
  localparam int TAP_LOG2 [N_TAP] = '{3, 5, 7};
  localparam int PSC_W  = 7;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'h0;
  localparam int                A_CMP_BASE = 2;
  localparam int                A_CAP_BASE = 8;

  typedef enum logic [1:0] {
    SRC_EXT    = 2'b00,
    SRC_DIV8   = 2'b01,
    SRC_DIV32  = 2'b10,
    SRC_DIV128 = 2'b11
  } src_sel_e;

  typedef struct packed {
    logic [N_CAP-1:0] cap_en;
    logic             dbuf;
    src_sel_e         src;
    logic             clr_en;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  output logic [N_TAP-1:0] tap_en
);
  logic [PSC_W-1:0] psc_q, psc_d;

  always_comb psc_d = psc_q + PSC_W'(1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) psc_q <= '0;
    else         psc_q <= psc_d;
  end

  for (genvar g = 0; g < N_TAP; g++) begin : g_tap
    assign tap_en[g] = &psc_q[TAP_LOG2[g]-1:0];
  end
endmodule

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_ni,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [2:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[1:0], pin};

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rise = sync_q[1] & ~sync_q[2];
  assign fall = ~sync_q[1] & sync_q[2];
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run,
  input  logic             clr_en,
  input  logic             tick,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] cnt_q,
  output logic             period_hit,
  output logic             match_a,
  output logic             match_b
);
  logic [CNT_W-1:0] cnt_d;
  logic             hit_a;
  logic             ma_q, mb_q;

  assign hit_a      = tick & (cnt_q == cmp_a);
  assign period_hit = tick & (cnt_q == cmp_b);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (tick) begin
      if (clr_en && (cnt_q == cmp_b)) cnt_d = '0;
      else                            cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ma_q  <= 1'b0;
      mb_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ma_q  <= hit_a;
      mb_q  <= period_hit;
    end
  end

  assign match_a = ma_q;
  assign match_b = mb_q;
endmodule

// File: rtl/tmr_capture.sv
module tmr_capture
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic [N_CAP-1:0]            cap_ev,
  input  logic [N_CAP-1:0]            cap_en,
  input  logic [CNT_W-1:0]            cnt,
  output logic [N_CAP-1:0][CNT_W-1:0] cap_val
);
  for (genvar g = 0; g < N_CAP; g++) begin : g_cap
    logic [CNT_W-1:0] cap_q, cap_d;
    logic             take;

    assign take = cap_ev[g] & cap_en[g];
    always_comb cap_d = take ? cnt : cap_q;

    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) cap_q <= '0;
      else         cap_q <= cap_d;
    end

    assign cap_val[g] = cap_q;
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_ni,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DATA_W-1:0]           wdata,
  input  logic                        period_hit,
  input  logic [N_CAP-1:0][CNT_W-1:0] cap_val,
  output ctrl_t                       ctrl,
  output logic [CNT_W-1:0]            cmp_a,
  output logic [CNT_W-1:0]            cmp_b,
  output logic [CNT_W-1:0]            buf_a,
  output logic [DATA_W-1:0]           rdata
);
  ctrl_t                        ctrl_q, ctrl_d;
  logic [N_CMP-1:0][DATA_W-1:0] hold_q, hold_d;
  logic [N_CMP-1:0][CNT_W-1:0]  cmp_q, cmp_d;
  logic [CNT_W-1:0]             buf_q, buf_d;
  logic [N_CAP-1:0][DATA_W-1:0] frz_q, frz_d;
  logic [DATA_W-1:0]            rdata_q, rdata_d;

  always_comb begin
    ctrl_d  = ctrl_q;
    hold_d  = hold_q;
    cmp_d   = cmp_q;
    buf_d   = buf_q;
    frz_d   = frz_q;
    rdata_d = rdata_q;

    // period boundary: shadow buffer moves into compare A
    if (period_hit && ctrl_q.dbuf) cmp_d[0] = buf_q;

    if (wr_en) begin
      if (addr == A_CTRL) ctrl_d = ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
      for (int i = 0; i < N_CMP; i++) begin
        if (addr == ADDR_W'(A_CMP_BASE + 2 * i)) hold_d[i] = wdata;
        if (addr == ADDR_W'(A_CMP_BASE + 2 * i + 1)) begin
          if (i == 0) begin
            buf_d = {wdata, hold_q[i]};
            if (!ctrl_q.dbuf) cmp_d[i] = {wdata, hold_q[i]};
          end else begin
            cmp_d[i] = {wdata, hold_q[i]};
          end
        end
      end
    end

    if (rd_en) begin
      rdata_d = '0;
      if (addr == A_CTRL) rdata_d = DATA_W'(ctrl_q);
      for (int i = 0; i < N_CAP; i++) begin
        if (addr == ADDR_W'(A_CAP_BASE + 2 * i)) begin
          rdata_d  = cap_val[i][DATA_W-1:0];
          frz_d[i] = cap_val[i][CNT_W-1:DATA_W];
        end
        if (addr == ADDR_W'(A_CAP_BASE + 2 * i + 1)) rdata_d = frz_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      hold_q  <= '0;
      cmp_q   <= '0;
      buf_q   <= '0;
      frz_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      hold_q  <= hold_d;
      cmp_q   <= cmp_d;
      buf_q   <= buf_d;
      frz_q   <= frz_d;
      rdata_q <= rdata_d;
    end
  end

  assign ctrl  = ctrl_q;
  assign cmp_a = cmp_q[0];
  assign cmp_b = cmp_q[1];
  assign buf_a = buf_q;
  assign rdata = rdata_q;
endmodule

// File: rtl/cmp_timer16.sv
module cmp_timer16
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_cnt_in,
  input  logic              cap_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              match_a,
  output logic              match_b
);
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [N_TAP-1:0]            tap_en;
  logic                        ext_rise, ext_fall;
  logic                        cap_rise, cap_fall;
  ctrl_t                       ctrl_w;
  logic [CNT_W-1:0]            cmp_a_w, cmp_b_w, buf_a_w, cnt_q;
  logic [N_CAP-1:0][CNT_W-1:0] cap_val;
  logic                        period_hit;
  logic                        src_en, tick;

  tmr_prescale u_psc (.clk(clk), .rst_ni(rst_ni), .tap_en(tap_en));

  tmr_edge_sync u_ext_sync (
    .clk(clk), .rst_ni(rst_ni), .pin(ext_cnt_in), .rise(ext_rise), .fall(ext_fall)
  );
  tmr_edge_sync u_cap_sync (
    .clk(clk), .rst_ni(rst_ni), .pin(cap_in), .rise(cap_rise), .fall(cap_fall)
  );

  always_comb begin
    unique case (ctrl_w.src)
      SRC_EXT:    src_en = ext_rise;
      SRC_DIV8:   src_en = tap_en[0];
      SRC_DIV32:  src_en = tap_en[1];
      SRC_DIV128: src_en = tap_en[2];
      default:    src_en = 1'b0;
    endcase
  end
  assign tick = ctrl_w.run & src_en;

  tmr_core u_core (
    .clk(clk), .rst_ni(rst_ni), .run(ctrl_w.run), .clr_en(ctrl_w.clr_en),
    .tick(tick), .cmp_a(cmp_a_w), .cmp_b(cmp_b_w), .cnt_q(cnt_q),
    .period_hit(period_hit), .match_a(match_a), .match_b(match_b)
  );

  tmr_capture u_cap (
    .clk(clk), .rst_ni(rst_ni), .cap_ev({cap_fall, cap_rise}),
    .cap_en(ctrl_w.cap_en), .cnt(cnt_q), .cap_val(cap_val)
  );

  tmr_regs u_regs (
    .clk(clk), .rst_ni(rst_ni), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .period_hit(period_hit), .cap_val(cap_val), .ctrl(ctrl_w),
    .cmp_a(cmp_a_w), .cmp_b(cmp_b_w), .buf_a(buf_a_w), .rdata(rdata)
  );

  logic unused_ext_fall;
  assign unused_ext_fall = ext_fall;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic             clk,
  input logic             rst_ni,
  input logic             run,
  input logic             clr_en,
  input logic             dbuf,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b,
  input logic [CNT_W-1:0] buf_a,
  input logic             match_a,
  input logic             match_b
);
  AST_STOPPED_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> cnt == '0); // R2

  AST_NO_TICK_HOLDS: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && !tick) |=> $stable(cnt)); // R1

  AST_PERIOD_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && tick && clr_en && cnt == cmp_b) |=> cnt == '0); // R3

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_ni)
    (run && tick && !(clr_en && cnt == cmp_b)) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1))); // R3

  AST_MATCH_A_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    match_a |=> !match_a); // R4

  AST_MATCH_B_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_ni)
    match_b |=> !match_b); // R4

  AST_SHADOW_ONLY: assert property (@(posedge clk) disable iff (!rst_ni)
    (dbuf && !(tick && cnt == cmp_b)) |=> $stable(cmp_a)); // R6

  AST_SHADOW_LOAD: assert property (@(posedge clk) disable iff (!rst_ni)
    (dbuf && tick && cnt == cmp_b) |=> cmp_a == $past(buf_a)); // R7
endmodule

bind cmp_timer16 tmr_checker u_chk (
  .clk(clk), .rst_ni(rst_ni), .run(ctrl_w.run), .clr_en(ctrl_w.clr_en),
  .dbuf(ctrl_w.dbuf), .tick(tick), .cnt(cnt_q), .cmp_a(cmp_a_w), .cmp_b(cmp_b_w),
  .buf_a(buf_a_w), .match_a(match_a), .match_b(match_b)
);

// File: tb/tb_cmp_timer16.sv
`timescale 1ns/1ps
module tb_cmp_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_cnt_in = 1'b0;
  logic       cap_in = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       match_a, match_b;

  always #2 clk = ~clk;

  cmp_timer16 dut (
    .clk(clk), .rst_n(rst_n), .ext_cnt_in(ext_cnt_in), .cap_in(cap_in),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .match_a(match_a), .match_b(match_b)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    live = 1'b0;
  bit    done = 1'b0;
  bit    pin_rand = 1'b0;
  logic  ext_dir = 1'b0;
  logic  cap_dir = 1'b0;
  string cur_req = "R10";

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  // ---------------- reference model built from the requirements ----------------
  logic [1:0]  m_rs;
  logic [6:0]  m_psc;
  logic [2:0]  m_es, m_cs;
  logic [6:0]  m_ctrl;
  logic [7:0]  m_hold_a, m_hold_b, m_frz0, m_frz1, m_rdata;
  logic [15:0] m_cmpa, m_cmpb, m_buf, m_cnt, m_cap0, m_cap1;
  logic        m_ma, m_mb;
  logic        t_tick, t_ph;

  function automatic logic f_src(input logic [6:0] psc, input logic [1:0] src, input logic erise);
    case (src)
      2'b00:   return erise;              // R1 external edges
      2'b01:   return psc[2:0] == 3'd7;   // R1 divide by 8
      2'b10:   return psc[4:0] == 5'd31;  // R1 divide by 32
      default: return psc == 7'd127;      // R1 divide by 128
    endcase
  endfunction

  function automatic logic [15:0] f_next(input logic [15:0] c, input logic run,
                                         input logic tk, input logic clr, input logic [15:0] b);
    if (!run) return 16'd0;               // R2
    if (!tk)  return c;
    if (clr && c == b) return 16'd0;      // R3
    return c + 16'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_rs <= 2'b00;
    else        m_rs <= {m_rs[0], 1'b1};
  end

  always @(posedge clk or negedge m_rs[1]) begin
    if (!m_rs[1]) begin
      m_psc <= '0; m_es <= '0; m_cs <= '0; m_ctrl <= '0;
      m_hold_a <= '0; m_hold_b <= '0; m_frz0 <= '0; m_frz1 <= '0; m_rdata <= '0;
      m_cmpa <= '0; m_cmpb <= '0; m_buf <= '0; m_cnt <= '0; m_cap0 <= '0; m_cap1 <= '0;
      m_ma <= 1'b0; m_mb <= 1'b0;
    end else begin
      t_tick = m_ctrl[0] & f_src(m_psc, m_ctrl[3:2], m_es[1] & ~m_es[2]);
      t_ph   = t_tick && (m_cnt == m_cmpb);
      m_psc <= m_psc + 7'd1;
      m_es  <= {m_es[1:0], ext_cnt_in};
      m_cs  <= {m_cs[1:0], cap_in};
      m_cnt <= f_next(m_cnt, m_ctrl[0], t_tick, m_ctrl[1], m_cmpb);
      m_ma  <= t_tick && (m_cnt == m_cmpa);
      m_mb  <= t_ph;
      if (m_ctrl[5] && m_cs[1] && !m_cs[2]) m_cap0 <= m_cnt;   // R8
      if (m_ctrl[6] && !m_cs[1] && m_cs[2]) m_cap1 <= m_cnt;
      if (t_ph && m_ctrl[4]) m_cmpa <= m_buf;                  // R7
      if (wr_en) begin
        case (addr)
          4'd0: m_ctrl <= wdata[6:0];
          4'd2: m_hold_a <= wdata;
          4'd3: begin
            m_buf <= {wdata, m_hold_a};
            if (!m_ctrl[4]) m_cmpa <= {wdata, m_hold_a};       // R6
          end
          4'd4: m_hold_b <= wdata;
          4'd5: m_cmpb <= {wdata, m_hold_b};
          default: ;
        endcase
      end
      if (rd_en) begin
        case (addr)
          4'd0:  m_rdata <= {1'b0, m_ctrl};
          4'd8:  begin m_rdata <= m_cap0[7:0]; m_frz0 <= m_cap0[15:8]; end
          4'd9:  m_rdata <= m_frz0;
          4'd10: begin m_rdata <= m_cap1[7:0]; m_frz1 <= m_cap1[15:8]; end
          4'd11: m_rdata <= m_frz1;
          default: m_rdata <= 8'd0;
        endcase
      end
    end
  end

  // ---------------- pins and continuous output checks ----------------
  always @(negedge clk) begin
    if (pin_rand) begin
      ext_cnt_in <= 1'($urandom_range(0, 1));
      if ($urandom_range(0, 5) == 0) cap_in <= ~cap_in;
    end else begin
      ext_cnt_in <= ext_dir;
      cap_in     <= cap_dir;
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk({"R4 ", cur_req}, "match_a", int'(match_a), int'(m_ma));
      chk({"R4 ", cur_req}, "match_b", int'(match_b), int'(m_mb));
    end
  end

  // ---------------- bus tasks ----------------
  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    wr(lo, v[7:0]);
    wr(lo + 4'd1, v[15:8]);
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    v = rdata;
    chk({"R9 ", cur_req}, "rdata", int'(rdata), int'(m_rdata));
  endtask

  task automatic pulse_cap();
    cap_dir = 1'b1; repeat (6) @(negedge clk);
    cap_dir = 1'b0; repeat (6) @(negedge clk);
  endtask

  task automatic ext_edges(input int n);
    for (int i = 0; i < n; i++) begin
      ext_dir = 1'b1; repeat (3) @(negedge clk);
      ext_dir = 1'b0; repeat (3) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
    end
  end

  initial begin
    logic [7:0] v, lo, hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // R10 reset state
    cur_req = "R10";
    rd(4'd0, v);
    chk("R10", "ctrl after reset", int'(v), 0);
    chk("R4", "match idle", int'(match_a | match_b), 0);
    rd(4'd7, v);
    chk("R10", "unmapped read", int'(v), 0);

    // R3 R5: period 9 on div-8, compare A at 4
    cur_req = "R3 R5";
    wr16(4'd4, 16'd9);
    wr16(4'd2, 16'd4);
    wr(4'd0, 8'h07);
    rd(4'd0, v);
    chk("R10", "ctrl readback", int'(v), 8'h07);
    repeat (300) @(negedge clk);

    // R5 lone low byte has no effect
    cur_req = "R5";
    wr(4'd2, 8'd2);
    repeat (200) @(negedge clk);

    // R2 stopped counter captures zero
    cur_req = "R2 R8";
    wr(4'd0, 8'h20);
    repeat (4) @(negedge clk);
    pulse_cap();
    rd(4'd8, lo); rd(4'd9, hi);
    chk("R2", "captured count while stopped", int'({hi, lo}), 0);

    // R8 capture disabled keeps old value, then R1 external counting
    cur_req = "R1 R8";
    wr(4'd0, 8'h01);
    ext_edges(5);
    pulse_cap();
    rd(4'd8, lo); rd(4'd9, hi);
    chk("R8", "capture off keeps zero", int'({hi, lo}), 0);
    wr(4'd0, 8'h61);
    ext_edges(5);
    pulse_cap();
    rd(4'd8, lo); rd(4'd9, hi);
    chk("R1", "ext edge count in capture 0", int'({hi, lo}), 10);
    rd(4'd10, lo); rd(4'd11, hi);
    chk("R8", "falling capture 1", int'({hi, lo}), 10);

    // R1 each internal tap
    for (int s = 1; s < 4; s++) begin
      cur_req = "R1";
      wr(4'd0, 8'h20);
      wr(4'd0, 8'(8'h21 | (s << 2)));
      repeat (600) @(negedge clk);
      pulse_cap();
      rd(4'd8, lo); rd(4'd9, hi);
    end

    // R6 R7 double buffering
    cur_req = "R6 R7";
    wr16(4'd4, 16'd12);
    wr16(4'd2, 16'd5);
    wr(4'd0, 8'h17);
    wr16(4'd2, 16'd9);
    repeat (400) @(negedge clk);

    // R9 capture between low and high reads
    cur_req = "R9";
    wr(4'd0, 8'h65);
    repeat (50) @(negedge clk);
    rd(4'd8, lo);
    pulse_cap();
    rd(4'd9, hi);

    // random mix: collisions of period match with buffer writes, capture with reads
    cur_req = "R3 R6 R7 R8 R9";
    pin_rand = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = int'($urandom_range(0, 9));
      case (op)
        0: wr(4'd0, 8'(($urandom_range(0, 127) & 8'h7e) | ($urandom_range(0, 9) != 0)));
        1, 2: wr(4'd2, 8'($urandom_range(0, 30)));
        3: wr(4'd3, 8'($urandom_range(0, 9) == 0));
        4: wr(4'd4, 8'($urandom_range(3, 30)));
        5: wr(4'd5, 8'h00);
        6: begin rd(4'd8, v); rd(4'd9, v); end
        7: begin rd(4'd10, v); rd(4'd11, v); end
        8: rd(4'(2 * $urandom_range(0, 7)), v);
        default: repeat ($urandom_range(1, 20)) @(negedge clk);
      endcase
    end
    pin_rand = 1'b0;
    repeat (10) @(negedge clk);
    done = 1'b1;
    report();
  end
endmodule